// File: doc/BRIEF.md
# Paged Packet Buffer Access Port

This block lets a host reach a paged packet memory one byte at a time. The memory sits inside the block. A 16-bit address register inside the block holds three things: the byte offset within a page, a flag that picks which page to use, and a flag that makes every data access step the offset forward. The host sees two targets. One is the address register, reached through a low byte and a high byte. The other is a four-byte data window. Two page numbers arrive as inputs: the page of the packet being built and the page at the head of the receive queue.

A single access moves from one to four bytes. The block breaks it into byte steps in little-endian order. Each byte step decodes its address on its own and applies the auto-step rule, so a four-byte access through the window with auto-step set touches four consecutive offsets. The controller is a state machine with four states:

- ST_IDLE: ready for a request.
- ST_XFER: performs one byte step.
- ST_WAIT: takes in the RAM read data.
- ST_DONE: presents the read result.

The transitions are:

- accept: ST_IDLE to ST_XFER, on a request.
- next-byte: ST_XFER to ST_XFER, when a write or address-register byte is done and more bytes remain.
- read-issue: ST_XFER to ST_WAIT, on a data-window read.
- read-next: ST_WAIT to ST_XFER, when more bytes remain.
- read-last: ST_WAIT to ST_DONE, after the final read byte.
- reg-read-last: ST_XFER to ST_DONE, after the final address-register read byte.
- write-last: ST_XFER to ST_IDLE, after the final write byte.
- release: ST_DONE to ST_IDLE.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the address register is 0x0000, `host_ready` is 1 and `host_rvalid` is 0.
- R2: A byte step to the address register (`host_sel`=0) writes or reads the low byte when bit 0 of its window address is 0, and the high byte when that bit is 1. Bits 10:0 of the register are the byte offset within a page.
- R3: A data step uses the page on `rxq_page` when address-register bit 15 is 1, and the page on `cur_page` when that bit is 0.
- R4: When address-register bit 14 is 1, each data step uses the current offset and then adds one to bits 10:0. The offset wraps from 0x7FF to 0x000, and bits 15:11 keep their values.
- R5: When bit 14 is 0, a data step uses the offset plus the two-bit window address of that byte, taken modulo 2048. The address register does not change.
- R6: Reading the high byte of the address register returns its stored value ANDed with 0xF7. A read of 0xFF written returns 0xF7.
- R7: An access of `host_size`+1 bytes starting at window address `host_addr` performs byte step i at window address (`host_addr`+i) mod 4. Step i carries `host_wdata`/`host_rdata` bits 8i+7:8i. Read-result bytes beyond the size are 0.
- R8: `host_ready` is 1 only in ST_IDLE. Counted in clock edges after the accepting edge:
  - A write of n bytes returns to ready after n edges.
  - An address-register read raises `host_rvalid` for exactly one cycle after n edges.
  - A data-window read raises `host_rvalid` for exactly one cycle after 2n edges.
- R9: Window reads and window writes decode page and offset by the same rules, so data written through one decoding reads back through another that names the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, taken when host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address register, 1 = data window |
| host_addr | input | 2 | Starting window address |
| host_size | input | 2 | Byte count minus one |
| host_wdata | input | 32 | Write bytes, little-endian |
| cur_page | input | PAGE_W | Page of the packet being built |
| rxq_page | input | PAGE_W | Page at the receive-queue head |
| host_ready | output | 1 | Idle and able to accept |
| host_rvalid | output | 1 | Read result valid, one-cycle pulse |
| host_rdata | output | 32 | Read result, little-endian |

## Verification
The bench drives each pattern against a behavioural byte-map model and checks the data and the edge count of every access.

- Four-byte window writes with auto-step set pin down lane order and the one-per-byte advance.
- Fixed-offset reads at unaligned window addresses with varied sizes expose a wrong lane sum or a lane that wraps the wrong way.
- Accesses that start at offset 0x7FE, in both modes, separate wrapping inside the page from a carry into the flag bits.
- Writing with bit 15 set and reading the same page back through `cur_page` shows that the page choice follows the flag.
- A high byte of 0xFF shows the 0xF7 mask.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } pdp_state_e;

    localparam int PTR_W        = 16;
    localparam int RXQ_FLAG_BIT = 15;
    localparam int AUTO_FLAG_BIT = 14;
    localparam logic [7:0] HI_READ_MASK = 8'hF7;
    localparam logic SEL_PTR  = 1'b0;
    localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
    import pdp_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wbyte,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_lo) begin
            ptr[7:0] <= wbyte;
        end else if (wr_hi) begin
            ptr[15:8] <= wbyte;
        end else if (step) begin
            ptr[OFS_W-1:0] <= ptr[OFS_W-1:0] + 1'b1;
        end
    end

    // R4: stepping advances only the offset field and keeps the flag bits
    a_r4_step_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_lo && !wr_hi) |=>
            (ptr[PTR_W-1:OFS_W] == $past(ptr[PTR_W-1:OFS_W])) &&
            (ptr[OFS_W-1:0] == OFS_W'($past(ptr[OFS_W-1:0]) + 1)));
endmodule

// File: rtl/pdp_ram.sv
module pdp_ram #(
    parameter int WORDS = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (en && we && be[g]) begin
                mem[addr][8*g +: 8] <= wdata[8*g +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en && !we) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
    import pdp_pkg::*;
#(
    parameter int PAGES  = 4,
    parameter int OFS_W  = 11,
    parameter int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [1:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [PAGE_W-1:0] rxq_page,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata
);
    localparam int ADDR_W  = PAGE_W + OFS_W;
    localparam int WORD_AW = ADDR_W - 2;
    localparam int WORDS   = 1 << WORD_AW;

    pdp_state_e state, nxt;

    logic        we_q, sel_q;
    logic [1:0]  base_q, last_q, idx_q, lane_q;
    logic [31:0] wdata_q, rdata_q;

    logic [PTR_W-1:0]  ptr;
    logic [1:0]        win;
    logic [7:0]        cur_byte;
    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
    logic [ADDR_W-1:0] byte_addr;
    logic              data_step, ptr_step, last_byte;
    logic              ram_we;
    logic [3:0]        ram_be;
    logic [31:0]       ram_rdata;
    logic [7:0]        ptr_rbyte;

    // Per-byte decode
    always_comb begin
        win       = base_q + idx_q;
        cur_byte  = wdata_q[{idx_q, 3'b000} +: 8];
        page      = ptr[RXQ_FLAG_BIT] ? rxq_page : cur_page;
        ofs       = ptr[AUTO_FLAG_BIT] ? ptr[OFS_W-1:0]
                                       : ptr[OFS_W-1:0] + OFS_W'(win);
        byte_addr = {page, ofs};
        data_step = (state == ST_XFER) && (sel_q == SEL_DATA);
        ptr_step  = (state == ST_XFER) && (sel_q == SEL_PTR);
        last_byte = (idx_q == last_q);
        ram_we    = data_step && we_q;
        ram_be    = 4'b0001 << byte_addr[1:0];
        ptr_rbyte = win[0] ? (ptr[15:8] & HI_READ_MASK) : ptr[7:0];
    end

    pdp_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (ptr_step && we_q && !win[0]),
        .wr_hi (ptr_step && we_q && win[0]),
        .wbyte (cur_byte),
        .step  (data_step && ptr[AUTO_FLAG_BIT]),
        .ptr   (ptr)
    );

    pdp_ram #(.WORDS(WORDS), .AW(WORD_AW)) u_ram (
        .clk   (clk),
        .en    (data_step),
        .we    (ram_we),
        .be    (ram_be),
        .addr  (byte_addr[ADDR_W-1:2]),
        .wdata ({4{cur_byte}}),
        .rdata (ram_rdata)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (host_req) nxt = ST_XFER;
            ST_XFER: begin
                if (sel_q == SEL_DATA && !we_q) nxt = ST_WAIT;
                else if (last_byte)             nxt = we_q ? ST_IDLE : ST_DONE;
                else                            nxt = ST_XFER;
            end
            ST_WAIT: nxt = last_byte ? ST_DONE : ST_XFER;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request capture and byte sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            sel_q   <= SEL_PTR;
            base_q  <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            lane_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (host_req) begin
                    we_q    <= host_we;
                    sel_q   <= host_sel;
                    base_q  <= host_addr;
                    last_q  <= host_size;
                    idx_q   <= '0;
                    wdata_q <= host_wdata;
                    rdata_q <= '0;
                end
                ST_XFER: begin
                    if (sel_q == SEL_DATA && !we_q) begin
                        lane_q <= byte_addr[1:0];
                    end else begin
                        if (sel_q == SEL_PTR && !we_q)
                            rdata_q[{idx_q, 3'b000} +: 8] <= ptr_rbyte;
                        if (!last_byte) idx_q <= idx_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    rdata_q[{idx_q, 3'b000} +: 8] <= ram_rdata[{lane_q, 3'b000} +: 8];
                    if (!last_byte) idx_q <= idx_q + 1'b1;
                end
                ST_DONE: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        host_ready  = (state == ST_IDLE);
        host_rvalid = (state == ST_DONE);
        host_rdata  = rdata_q;
    end

    // R5: a fixed-offset data step leaves the address register untouched
    a_r5_fixed_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !ptr[AUTO_FLAG_BIT]) |=> $stable(ptr));
    // R8: read result is a single-cycle pulse
    a_r8_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);
    // R8: every data read byte spends one cycle waiting for the RAM
    a_r8_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !we_q) |=> (state == ST_WAIT));
    // R8: an accepted request makes the port busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_req) |=> !host_ready);
endmodule

// File: tb/pkt_data_port_test.sv
`timescale 1ns/1ps
module pkt_data_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
    logic [1:0]  host_addr = '0, host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [1:0]  cur_page = '0, rxq_page = '0;
    logic        host_ready, host_rvalid;
    logic [31:0] host_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0]  mem [int];
    logic [15:0] mptr = 16'h0000;

    always #4 clk = ~clk;

    pkt_data_port uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_sel(host_sel), .host_addr(host_addr), .host_size(host_size),
        .host_wdata(host_wdata), .cur_page(cur_page), .rxq_page(rxq_page),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of one access plus cycle-by-cycle observation of the port
    task automatic acc(input bit we, input bit sel, input int a, input int n,
                       input logic [31:0] wd, input string tag);
        logic [31:0] exp_rd = '0;
        int exp_c, c, busy_bad;
        bit done;
        for (int i = 0; i < n; i++) begin
            int lane = (a + i) & 3;
            if (!sel) begin
                if (we) begin
                    if (lane & 1) mptr[15:8] = wd[8*i +: 8];
                    else          mptr[7:0]  = wd[8*i +: 8];
                end else begin
                    exp_rd[8*i +: 8] = (lane & 1) ? (mptr[15:8] & 8'hF7) : mptr[7:0];
                end
            end else begin
                int pg  = mptr[15] ? int'(rxq_page) : int'(cur_page);
                int off = mptr[14] ? int'(mptr[10:0]) : ((int'(mptr[10:0]) + lane) % 2048);
                int key = pg * 2048 + off;
                if (we) mem[key] = wd[8*i +: 8];
                else    exp_rd[8*i +: 8] = mem.exists(key) ? mem[key] : 8'h00;
                if (mptr[14]) mptr[10:0] = mptr[10:0] + 11'd1;
            end
        end
        exp_c = (sel && !we) ? 2 * n : n;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_sel = sel;
        host_addr = 2'(a); host_size = 2'(n - 1); host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        c = 0; done = 0; busy_bad = 0;
        while (!done && c < 40) begin
            if (we ? host_ready : host_rvalid) done = 1;
            else begin
                if (host_ready) busy_bad++;
                c++;
                @(negedge clk);
            end
        end
        check(c == exp_c, {tag, " R8 edge count"}, 32'(c), 32'(exp_c));
        check(busy_bad == 0, {tag, " R8 ready low while busy"}, 32'(busy_bad), 32'd0);
        if (!we) begin
            check(host_rdata === exp_rd, {tag, " read data"}, host_rdata, exp_rd);
            @(negedge clk);
            check(host_rvalid == 1'b0, {tag, " R8 rvalid single cycle"}, 32'(host_rvalid), 32'd0);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready == 1'b1, "R1 ready after reset", 32'(host_ready), 32'd1);
        check(host_rvalid == 1'b0, "R1 rvalid after reset", 32'(host_rvalid), 32'd0);
        acc(0, 0, 0, 2, 0, "R1 pointer reads zero");

        // R2 R7 R4: auto-step write of four bytes through the window
        cur_page = 2'd1; rxq_page = 2'd2;
        acc(1, 0, 0, 2, 32'h0000_4010, "R2 pointer write");
        acc(1, 1, 0, 4, 32'hDDCC_BBAA, "R7 wide write");
        acc(0, 0, 0, 2, 0, "R4 pointer advanced by four");

        // R5 R9: fixed offset, lane sum, unaligned and wrapping lanes
        acc(1, 0, 0, 2, 32'h0000_0010, "R2 pointer fixed mode");
        acc(0, 1, 0, 4, 0, "R9 R5 fixed read all lanes");
        acc(0, 1, 2, 1, 0, "R5 single lane two");
        acc(0, 1, 3, 2, 0, "R7 R5 lanes three then zero");
        acc(0, 0, 1, 1, 0, "R5 pointer unchanged high");
        acc(0, 0, 0, 1, 0, "R5 pointer unchanged low");

        // R4: offset wraps inside the page, flags untouched
        acc(1, 0, 0, 2, 32'h0000_47FE, "R4 pointer near end");
        acc(1, 1, 0, 4, 32'h4433_2211, "R4 wrapping write");
        acc(0, 0, 0, 2, 0, "R4 wrapped pointer");
        acc(1, 0, 0, 2, 32'h0000_07FE, "R5 pointer near end fixed");
        acc(0, 1, 0, 4, 0, "R5 fixed read wraps in page");

        // R3: page chosen by bit 15
        acc(1, 0, 0, 2, 32'h0000_C000, "R3 pointer rx head");
        acc(1, 1, 1, 2, 32'h0000_5A66, "R3 write to rx head page");
        acc(1, 0, 0, 2, 32'h0000_0000, "R3 pointer current page");
        acc(0, 1, 0, 1, 0, "R3 current page byte");
        cur_page = 2'd2;
        acc(0, 1, 0, 2, 0, "R3 R9 rx data via current page");

        // R6: high byte read mask, and R4 wrap from 0x7FF with all flags set
        acc(1, 0, 0, 2, 32'h0000_FFFF, "R6 pointer all ones");
        acc(0, 0, 1, 1, 0, "R6 masked high byte");
        acc(1, 1, 0, 1, 32'h0000_0077, "R4 step at last offset");
        acc(0, 0, 0, 2, 0, "R4 R6 flags kept after wrap");
        acc(0, 0, 2, 4, 0, "R7 R2 pointer lanes alternate");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule